// File: doc/BRIEF.md
# RGB LED Matrix Scan Driver with Write-Side Gamma

This block drives a 32 x 16 RGB LED panel that has no brightness control of its own. A processor writes pixels through a simple write port: a pixel address and three 8-bit intensities. Each intensity passes through a fixed gamma curve and is stored as a linear level of `DEPTH` bits, which is 10 by default and may be set to 9. The curve is built when the block is elaborated; it cannot be loaded at run time. The correction sits on the write path, so the display path only reads stored levels.

Storage is split into six banks: red, green and blue for the upper half of the panel, and the same three for the lower half. A single read address therefore returns all six colour words that one column of a row pair needs. The scan engine takes the row pairs in turn. For each row pair it presents every bit plane, from the least significant to the most significant. For each plane it shifts out 32 columns, pulses the latch while the panel is dark, and then enables the LEDs for a time in proportion to the weight of that plane (binary-coded modulation).

Each column takes four core clocks. A 160 MHz core clock therefore gives a 40 MHz panel shift rate, with all six banks read in the same cycle.

Top module: `led_matrix_driver`

## Requirements
- R1: `wrAddr` holds the pixel row in bits [8:5] and the column in bits [4:0]. Rows 0 to 7 belong to the upper half of the panel and rows 8 to 15 to the lower half.
- R2: A written 8-bit code v is stored as the level (v*v*(2^DEPTH-1) + 32512) / 65025, using integer division. With the default DEPTH of 10, code 0 gives 0 and code 255 gives 1023.
- R3: `wrAck` is high for one cycle, exactly two cycles after each cycle in which `wrEn` is high. Writes may be issued on every cycle.
- R4: While `panelRow` = r, bits 0, 1 and 2 of `panelRgb` carry red, green and blue of row r, and bits 3, 4 and 5 carry red, green and blue of row r+8.
- R5: Each displayed line consists of exactly 32 rising edges of `panelClk`, with column 0 shifted first. `panelRgb` is stable on the cycle before each rising edge.
- R6: For bit plane k, the shifted bit of each channel is bit k of its stored level. Planes run from 0 to DEPTH-1 within a row pair, and row pairs run upward from 0 and wrap after 7.
- R7: After each latch, `panelOeN` is low for exactly BASE_TICKS*2^k consecutive cycles, where k is the plane just latched.
- R8: `panelLatch` is a single-cycle pulse that follows the 32nd clock of a line. Both it and `panelRow` change only while `panelOeN` is high.
- R9: During reset, `panelOeN` is 1 and `panelLatch`, `panelClk` and `wrAck` are 0. After reset the scan starts at row pair 0, plane 0. Stored levels survive reset.
- R10: `panelClk` is never high while `panelOeN` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Pixel write strobe |
| wrAddr | input | 9 | Pixel address {row[3:0], col[4:0]} |
| wrRed | input | 8 | Red intensity code |
| wrGreen | input | 8 | Green intensity code |
| wrBlue | input | 8 | Blue intensity code |
| wrAck | output | 1 | Write committed, two cycles after `wrEn` |
| panelClk | output | 1 | Panel shift clock |
| panelLatch | output | 1 | Panel row latch pulse |
| panelOeN | output | 1 | Panel output enable, active low |
| panelRow | output | 3 | Row-pair address |
| panelRgb | output | 6 | Colour data {B,G,R lower, B,G,R upper} |

## Verification
The frame is first filled with seeded random codes, with directed corner codes at the first pixel, the last pixel and the first pixel of the lower half. A reset then lets a complete frame be compared against the expected levels. A random fill can show that bits land in the right bank, plane and column. The corners 0, 1, 254 and 255 show whether the gamma rounding is correct and whether the planes are ordered correctly at both ends of the range. A second pass writes a few isolated pixels, which shows the difference between back-to-back and single write acknowledges and confirms that earlier contents survive reset. The length of every enable pulse is compared against the doubling sequence.

// File: rtl/lpd_pkg.sv
package lpd_pkg;
  parameter int PANEL_COLS = 32;
  parameter int PANEL_ROWS = 16;
  parameter int CHAN_W     = 8;
  localparam int COL_W      = $clog2(PANEL_COLS);
  localparam int HALF_ROWS  = PANEL_ROWS / 2;
  localparam int PAIR_W     = $clog2(HALF_ROWS);
  localparam int ROW_W      = PAIR_W + 1;
  localparam int PIX_W      = ROW_W + COL_W;
  localparam int BANK_AW    = PAIR_W + COL_W;
  localparam int BANK_DEPTH = HALF_ROWS * PANEL_COLS;
  localparam int NUM_CHAN   = 3;
  localparam int NUM_BANKS  = 2 * NUM_CHAN;
  localparam int PLANE_W    = 4;

  typedef enum logic [1:0] {ST_SHIFT, ST_LATCH, ST_SHOW} scanState_e;

  // Strobes from the scan control to the datapath.
  typedef struct packed {
    logic [PAIR_W-1:0]  rdRow;
    logic [COL_W-1:0]   rdCol;
    logic [PLANE_W-1:0] plane;
    logic               loadBits;
  } scanStrobe_t;

  // Square-law gamma curve, rounded to nearest.
  function automatic int gammaLevel(int code, int depth);
    int top;
    int full;
    top  = (1 << depth) - 1;
    full = (1 << CHAN_W) - 1;
    return (code * code * top + (full * full) / 2) / (full * full);
  endfunction
endpackage

// File: rtl/lpd_datapath.sv
module lpd_datapath
  import lpd_pkg::*;
#(
  parameter int DEPTH = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [PIX_W-1:0]  wrAddr,
  input  logic [CHAN_W-1:0] wrRed,
  input  logic [CHAN_W-1:0] wrGreen,
  input  logic [CHAN_W-1:0] wrBlue,
  output logic              wrAck,
  input  scanStrobe_t       strobe,
  output logic [NUM_BANKS-1:0] rgbOut
);
  localparam int ROM_SIZE = 1 << CHAN_W;

  // Gamma table fixed at elaboration.
  logic [DEPTH-1:0] gammaRom [ROM_SIZE];
  for (genvar g = 0; g < ROM_SIZE; g++) begin : g_rom
    assign gammaRom[g] = DEPTH'(gammaLevel(g, DEPTH));
  end

  logic [CHAN_W-1:0] chanIn [NUM_CHAN];
  assign chanIn[0] = wrRed;
  assign chanIn[1] = wrGreen;
  assign chanIn[2] = wrBlue;

  // Stage 1: table lookup.
  logic             s1Valid;
  logic [PIX_W-1:0] s1Addr;
  logic [DEPTH-1:0] s1Level [NUM_CHAN];

  always_ff @(posedge clk) begin
    if (rst) begin
      s1Valid <= 1'b0;
      wrAck   <= 1'b0;
    end else begin
      s1Valid <= wrEn;
      wrAck   <= s1Valid;
    end
  end

  always_ff @(posedge clk) begin
    if (wrEn) begin
      s1Addr <= wrAddr;
      for (int ch = 0; ch < NUM_CHAN; ch++) begin
        s1Level[ch] <= gammaRom[chanIn[ch]];
      end
    end
  end

  // Stage 2: bank write; all six banks read in parallel every cycle.
  logic [NUM_BANKS-1:0] planeBit;
  logic [BANK_AW-1:0]   rdAddr;
  assign rdAddr = {strobe.rdRow, strobe.rdCol};

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int HALF = b / NUM_CHAN;
    localparam int CH   = b % NUM_CHAN;
    logic [DEPTH-1:0] mem [BANK_DEPTH];
    logic [DEPTH-1:0] bankQ;
    logic             bankWe;
    assign bankWe = s1Valid && (s1Addr[PIX_W-1] == 1'(HALF));
    always_ff @(posedge clk) begin
      if (bankWe) mem[s1Addr[BANK_AW-1:0]] <= s1Level[CH];
      bankQ <= mem[rdAddr];
    end
    assign planeBit[b] = bankQ[strobe.plane];
  end

  always_ff @(posedge clk) begin
    if (rst) rgbOut <= '0;
    else if (strobe.loadBits) rgbOut <= planeBit;
  end

  logic [1:0] upCnt;
  always_ff @(posedge clk) begin
    if (rst) upCnt <= 2'd0;
    else if (upCnt != 2'd2) upCnt <= upCnt + 2'd1;
  end

  AST_ACK_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (upCnt == 2'd2) |-> (wrAck == $past(wrEn, 2))) else $error("ack latency"); // R3
endmodule

// File: rtl/lpd_scan_ctrl.sv
module lpd_scan_ctrl
  import lpd_pkg::*;
#(
  parameter int DEPTH      = 10,
  parameter int BASE_TICKS = 1
) (
  input  logic              clk,
  input  logic              rst,
  output scanStrobe_t       strobe,
  output logic              panelClk,
  output logic              panelLatch,
  output logic              panelOeN,
  output logic [PAIR_W-1:0] panelRow
);
  localparam int SHOW_W = $clog2(BASE_TICKS << DEPTH) + 1;

  scanState_e        state;
  logic [COL_W-1:0]  col;
  logic [1:0]        phase;
  logic [PLANE_W-1:0] plane;
  logic [PAIR_W-1:0] pair;
  logic [SHOW_W-1:0] showCnt;
  logic [SHOW_W-1:0] showLen;
  logic              lastCol;
  logic              lastPlane;

  assign showLen   = SHOW_W'(BASE_TICKS) << plane;
  assign lastCol   = (col == COL_W'(PANEL_COLS - 1));
  assign lastPlane = (plane == PLANE_W'(DEPTH - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_SHIFT;
      col        <= '0;
      phase      <= 2'd0;
      plane      <= '0;
      pair       <= '0;
      showCnt    <= '0;
      panelClk   <= 1'b0;
      panelLatch <= 1'b0;
      panelOeN   <= 1'b1;
      panelRow   <= '0;
    end else begin
      case (state)
        ST_SHIFT: begin
          phase    <= phase + 2'd1;
          panelClk <= (phase == 2'd2);
          if (phase == 2'd3) begin
            if (lastCol) begin
              state      <= ST_LATCH;
              panelLatch <= 1'b1;
              panelRow   <= pair;
              col        <= '0;
            end else begin
              col <= col + COL_W'(1);
            end
          end
        end
        ST_LATCH: begin
          panelLatch <= 1'b0;
          panelOeN   <= 1'b0;
          showCnt    <= showLen - SHOW_W'(1);
          state      <= ST_SHOW;
        end
        ST_SHOW: begin
          if (showCnt == '0) begin
            panelOeN <= 1'b1;
            state    <= ST_SHIFT;
            phase    <= 2'd0;
            if (lastPlane) begin
              plane <= '0;
              pair  <= pair + PAIR_W'(1);
            end else begin
              plane <= plane + PLANE_W'(1);
            end
          end else begin
            showCnt <= showCnt - SHOW_W'(1);
          end
        end
        default: state <= ST_SHIFT;
      endcase
    end
  end

  assign strobe.rdRow    = pair;
  assign strobe.rdCol    = col;
  assign strobe.plane    = plane;
  assign strobe.loadBits = (state == ST_SHIFT) && (phase == 2'd1);

  AST_ROW_BLANKED: assert property (@(posedge clk) disable iff (rst)
    !$stable(panelRow) |-> panelOeN) else $error("row moved while lit"); // R8
  AST_LATCH_BLANKED: assert property (@(posedge clk) disable iff (rst)
    panelLatch |-> panelOeN) else $error("latch while lit"); // R8
  AST_LATCH_PULSE: assert property (@(posedge clk) disable iff (rst)
    panelLatch |=> !panelLatch) else $error("latch too long"); // R8
  AST_CLK_BLANKED: assert property (@(posedge clk) disable iff (rst)
    panelClk |-> panelOeN) else $error("shift while lit"); // R10
endmodule

// File: rtl/led_matrix_driver.sv
module led_matrix_driver #(
  parameter int DEPTH      = 10,
  parameter int BASE_TICKS = 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wrEn,
  input  logic [8:0] wrAddr,
  input  logic [7:0] wrRed,
  input  logic [7:0] wrGreen,
  input  logic [7:0] wrBlue,
  output logic       wrAck,
  output logic       panelClk,
  output logic       panelLatch,
  output logic       panelOeN,
  output logic [2:0] panelRow,
  output logic [5:0] panelRgb
);
  lpd_pkg::scanStrobe_t strobe;

  lpd_scan_ctrl #(.DEPTH(DEPTH), .BASE_TICKS(BASE_TICKS)) ctrl_i (
    .clk(clk), .rst(rst), .strobe(strobe),
    .panelClk(panelClk), .panelLatch(panelLatch),
    .panelOeN(panelOeN), .panelRow(panelRow)
  );

  lpd_datapath #(.DEPTH(DEPTH)) dp_i (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrRed(wrRed), .wrGreen(wrGreen), .wrBlue(wrBlue),
    .wrAck(wrAck), .strobe(strobe), .rgbOut(panelRgb)
  );

  AST_DATA_STABLE: assert property (@(posedge clk) disable iff (rst)
    $rose(panelClk) |-> $stable(panelRgb)) else $error("data moved at shift edge"); // R5
endmodule

// File: tb/led_matrix_driver_tb_top.sv
`timescale 1ns/1ps
module led_matrix_driver_tb_top;
  localparam int D    = 10;
  localparam int BASE = 1;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wrEn = 1'b0;
  logic [8:0] wrAddr = '0;
  logic [7:0] wrRed = '0, wrGreen = '0, wrBlue = '0;
  logic       wrAck, panelClk, panelLatch, panelOeN;
  logic [2:0] panelRow;
  logic [5:0] panelRgb;

  always #4 clk = ~clk;

  led_matrix_driver #(.DEPTH(D), .BASE_TICKS(BASE)) dut_i (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrRed(wrRed), .wrGreen(wrGreen), .wrBlue(wrBlue), .wrAck(wrAck),
    .panelClk(panelClk), .panelLatch(panelLatch), .panelOeN(panelOeN),
    .panelRow(panelRow), .panelRgb(panelRgb)
  );

  int vectors = 0;
  int errors  = 0;
  int linesChecked = 0;
  bit checkOn = 0;
  bit done = 0;
  int expMem [6][256];

  function automatic int benchGamma(int v);
    return (v * v * ((1 << D) - 1) + 32512) / 65025;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drivePix(int row, int col, int r, int g, int b);
    int half;
    @(posedge clk); #1;
    wrEn = 1'b1;
    wrAddr = {row[3:0], col[4:0]};          // R1 address layout
    wrRed = r[7:0]; wrGreen = g[7:0]; wrBlue = b[7:0];
    half = row / 8;
    expMem[half*3 + 0][(row % 8) * 32 + col] = benchGamma(r);  // R2
    expMem[half*3 + 1][(row % 8) * 32 + col] = benchGamma(g);
    expMem[half*3 + 2][(row % 8) * 32 + col] = benchGamma(b);
  endtask

  // Write acknowledge monitor (R3)
  bit ackH1 = 0, ackH2 = 0;
  always @(negedge clk) begin
    if (rst) begin
      ackH1 = 0; ackH2 = 0;
    end else begin
      if (ackH2 || wrAck) check(wrAck == ackH2, "R3 ack latency", int'(wrAck), int'(ackH2));
      ackH2 = ackH1;
      ackH1 = wrEn;
    end
  end

  // Panel monitor
  logic [5:0] cap [32];
  int shiftIdx, oeRun, expPair, expPlane;
  bit prevClk, prevOeN;
  logic [2:0] prevRow;
  always @(negedge clk) begin
    if (rst) begin
      shiftIdx = 0; oeRun = 0; expPair = 0; expPlane = 0;
      prevClk = 0; prevOeN = 1; prevRow = 3'd0;
    end else if (checkOn) begin
      if (panelClk && !panelOeN) check(0, "R10 clock while lit", 1, 0);
      if (panelRow != prevRow && !panelOeN) check(0, "R8 row moved while lit", int'(panelRow), int'(prevRow));
      if (panelClk && !prevClk) begin
        if (shiftIdx < 32) cap[shiftIdx] = panelRgb;
        shiftIdx++;
      end
      if (panelLatch) begin
        check(shiftIdx == 32, "R5 clocks per line", shiftIdx, 32);
        check(panelOeN == 1'b1, "R8 latch while blanked", int'(panelOeN), 1);
        check(int'(panelRow) == expPair, "R6 row pair order", int'(panelRow), expPair);
        shiftIdx = 0;
      end
      if (!panelOeN) oeRun++;
      if (panelOeN && !prevOeN) begin
        logic [191:0] actBits, expBits;
        check(oeRun == (BASE << expPlane), "R7 enable time", oeRun, BASE << expPlane);
        for (int c = 0; c < 32; c++) begin
          for (int ch = 0; ch < 6; ch++) begin
            actBits[c*6 + ch] = cap[c][ch];
            expBits[c*6 + ch] = 1'((expMem[ch][expPair*32 + c] >> expPlane) & 1);
          end
        end
        // R1 R4 R6 R9: plane bits per column and half
        check(actBits == expBits, "R4 R6 plane bits", expPair, expPlane);
        oeRun = 0;
        linesChecked++;
        if (expPlane == D - 1) begin
          expPlane = 0;
          expPair = (expPair + 1) % 8;
        end else begin
          expPlane++;
        end
      end
    end
    prevClk = panelClk;
    prevOeN = panelOeN;
    prevRow = panelRow;
  end

  task automatic checkResetState();
    @(negedge clk);
    check(panelOeN == 1'b1, "R9 reset oe", int'(panelOeN), 1);
    check(panelLatch == 1'b0, "R9 reset latch", int'(panelLatch), 0);
    check(panelClk == 1'b0, "R9 reset clk", int'(panelClk), 0);
    check(wrAck == 1'b0, "R9 reset ack", int'(wrAck), 0);
  endtask

  task automatic restartAndCheck(int target);
    @(posedge clk); #1;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    checkResetState();
    @(posedge clk); #1;
    rst = 1'b0;
    checkOn = 1;
    while (linesChecked < target) @(posedge clk);
    checkOn = 0;
  endtask

  initial begin
    int unsigned seedSink;
    int r, g, b;
    seedSink = $urandom(32'd2024);
    repeat (4) @(posedge clk);
    checkResetState();
    @(posedge clk); #1;
    rst = 1'b0;
    // Full frame, back-to-back writes
    for (int p = 0; p < 512; p++) begin
      r = int'($urandom % 256); g = int'($urandom % 256); b = int'($urandom % 256);
      if (p == 0)   begin r = 0;   g = 255; b = 1;   end
      if (p == 256) begin r = 128; g = 1;   b = 254; end
      if (p == 511) begin r = 255; g = 0;   b = 128; end
      drivePix(p / 32, p % 32, r, g, b);
    end
    @(posedge clk); #1;
    wrEn = 1'b0;
    repeat (4) @(posedge clk);
    check(benchGamma(255) == 1023 && benchGamma(0) == 0, "R2 curve ends", benchGamma(255), 1023);
    restartAndCheck(8 * D);
    // Isolated writes with directed corner codes
    for (int i = 0; i < 16; i++) begin
      int corner;
      corner = (i % 4 == 0) ? 0 : (i % 4 == 1) ? 255 : (i % 4 == 2) ? 1 : 254;
      drivePix(int'($urandom % 16), int'($urandom % 32), corner, 255 - corner, corner);
      @(posedge clk); #1;
      wrEn = 1'b0;
      repeat (1 + int'($urandom % 3)) @(posedge clk);
    end
    repeat (4) @(posedge clk);
    restartAndCheck(16 * D);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 150000 && !done; i++) @(posedge clk);
    if (!done) begin
      vectors++;
      errors++;
      $display("FAIL watchdog R6 actual %0d lines expected %0d", linesChecked, 16 * D);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule